// File: doc/BRIEF.md
# Gated LFSR Signature Analyzer

This block condenses a serial bit stream into a 16-bit signature. It watches four slow probe lines: a probe clock, a START qualifier, a STOP qualifier and a data line. None of them is related to the system clock. Each line passes through a synchronizer. The probe clock's selected edge is then detected on the system clock, and on that edge the other three lines are sampled. A START edge opens a capture window. While the window is open, every sampled data bit is folded into a right-shifting linear feedback register. A STOP edge closes the window. At that point the register value is published as the signature together with a one-cycle valid pulse, and the register is reset to zero for the next window.

Alongside the raw signature, the block gives four 5-bit character codes, one for each nibble, taken from a fixed sixteen-symbol alphabet. These codes can drive a display directly. The edge polarity of the probe clock, of START and of STOP can each be chosen separately. Qualifier edges are judged only between consecutive probe samples, never between system clock cycles.

Top module: `gated_sig_analyzer`

## Requirements
- R1: Sampling happens only on the selected probe clock edge. `clkEdgeSel`=1 selects rising and 0 selects falling. The opposite edge of the probe clock samples nothing.
- R2: On each sample taken while the window is open, the new bit is `dataIn` XOR register bits 0, 4, 7 and 9. The register shifts right by one, and the new bit enters at bit 15.
- R3: A START transition to the active level opens the window. The active level is 1 when `startEdgeSel`=1 and 0 when `startEdgeSel`=0. The data bit of the opening sample is folded into the register.
- R4: A STOP transition to the active level (1 for `stopEdgeSel`=1, 0 otherwise) closes the window. The data bit of the closing sample is not folded in. `signature` takes the register value, and the register restarts from zero, so two identical windows yield the same signature.
- R5: START is ignored while the window is open, and STOP is ignored while it is closed. When both lines change on the same sample while the window is closed, only the opening takes effect.
- R6: A qualifier edge is the difference between the level at this probe sample and the level at the previous probe sample. A START pulse that rises and falls between two probe samples opens nothing.
- R7: Reset loads the remembered START and STOP levels with the inactive level of their selected edge. A line that is already at its active level at reset therefore counts as an edge on the first sample.
- R8: `sigValid` is high for exactly one system clock cycle for each window close. `signature` and the character outputs hold their values until the next close.
- R9: `char0` codes bits 3:0, `char1` bits 7:4, `char2` bits 11:8 and `char3` bits 15:12. Write a nibble as b3 b2 b1 b0. The codes are: 0000=0, 1000=1, 0100=2, 1100=3, 0010=4, 1010=5, 0110=6, 1110=7, 0001=8, 1001=9, 0101=10 (A), 1101=12 (C), 0011=15 (F), 1011=17 (H), 0111=25 (P), 1111=30 (U). A code is the symbol's position in the sequence of digits 0-9 followed by letters A-V.
- R10: A synchronous reset clears `sigValid`, `signature` and all character codes to zero, and closes the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clkEdgeSel | input | 1 | Probe clock active edge: 1 rising, 0 falling |
| startEdgeSel | input | 1 | START edge: 1 rising, 0 falling |
| stopEdgeSel | input | 1 | STOP edge: 1 rising, 0 falling |
| probeClk | input | 1 | Asynchronous probe clock |
| startIn | input | 1 | Asynchronous START qualifier |
| stopIn | input | 1 | Asynchronous STOP qualifier |
| dataIn | input | 1 | Asynchronous serial data |
| sigValid | output | 1 | One-cycle pulse when a new signature is published |
| signature | output | 16 | Last published signature |
| char0 | output | 5 | Character code of bits 3:0 |
| char1 | output | 5 | Character code of bits 7:4 |
| char2 | output | 5 | Character code of bits 11:8 |
| char3 | output | 5 | Character code of bits 15:12 |

## Verification
A window opening and a window closing can land on the same probe sample, because START and STOP may both change between two probe edges. The bench provokes this in two ways. It raises both qualifiers at once while the window is closed. It also lets the random stimulus toggle both lines freely, including toggles of START while the window is open. A bench model that evaluates START first, and STOP only in the open state, predicts the outcome. The bench judges each case by whether a valid pulse appears after that sample, and by whether the signature that follows includes the opening bit.

// File: rtl/sigan_pkg.sv
package sigan_pkg;

  localparam int SIG_W  = 16;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;
  localparam int NIBBLES = SIG_W / NIB_W;

  typedef enum logic {
    WIN_SHUT = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

  // Strobes from control to datapath, valid for one system clock.
  typedef struct packed {
    logic shiftEn;
    logic closeEn;
    logic dataBit;
  } sigan_strobe_t;

  // Reverse the nibble so bit 3 is read first, then place it in the
  // digits-then-letters symbol sequence.
  function automatic logic [CODE_W-1:0] nibbleToCode(input logic [NIB_W-1:0] nib);
    logic [NIB_W-1:0] rev;
    logic [CODE_W-1:0] code;
    for (int i = 0; i < NIB_W; i++) rev[i] = nib[NIB_W-1-i];
    if (rev < 4'd10) begin
      code = {1'b0, rev};
    end else begin
      unique case (rev)
        4'd10:   code = 5'd10;
        4'd11:   code = 5'd12;
        4'd12:   code = 5'd15;
        4'd13:   code = 5'd17;
        4'd14:   code = 5'd25;
        default: code = 5'd30;
      endcase
    end
    return code;
  endfunction

endpackage

// File: rtl/sigan_sync.sv
module sigan_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/sigan_ctrl.sv
module sigan_ctrl
  import sigan_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          clkEdgeSel,
  input  logic          startEdgeSel,
  input  logic          stopEdgeSel,
  input  logic          pclkS,
  input  logic          startS,
  input  logic          stopS,
  input  logic          dataS,
  output sigan_strobe_t strb
);

  logic       pclkD;
  logic       startPrev;
  logic       stopPrev;
  win_state_e winState;
  logic       sampleEn;
  logic       startHit;
  logic       stopHit;

  // Probe clock edge seen on the system clock.
  assign sampleEn = !rst && (clkEdgeSel ? (pclkS && !pclkD) : (!pclkS && pclkD));

  // Active level equals the select: 1 for rising, 0 for falling.
  assign startHit = (startS != startPrev) && (startS == startEdgeSel);
  assign stopHit  = (stopS  != stopPrev)  && (stopS  == stopEdgeSel);

  always_comb begin
    strb         = '0;
    strb.dataBit = dataS;
    if (sampleEn) begin
      unique case (winState)
        WIN_SHUT: strb.shiftEn = startHit;
        WIN_OPEN: begin
          strb.closeEn = stopHit;
          strb.shiftEn = !stopHit;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pclkD     <= 1'b0;
      startPrev <= !startEdgeSel;
      stopPrev  <= !stopEdgeSel;
      winState  <= WIN_SHUT;
    end else begin
      pclkD <= pclkS;
      if (sampleEn) begin
        startPrev <= startS;
        stopPrev  <= stopS;
        if (winState == WIN_SHUT && startHit) winState <= WIN_OPEN;
        else if (winState == WIN_OPEN && stopHit) winState <= WIN_SHUT;
      end
    end
  end

endmodule

// File: rtl/sigan_datapath.sv
module sigan_datapath
  import sigan_pkg::*;
#(
  parameter logic [SIG_W-1:0] TAP_MASK = 16'h0291
) (
  input  logic                            clk,
  input  logic                            rst,
  input  sigan_strobe_t                   strb,
  output logic                            sigValid,
  output logic [SIG_W-1:0]                signature,
  output logic [NIBBLES-1:0][CODE_W-1:0]  chars
);

  logic [SIG_W-1:0]               lfsr;
  logic                           feedBit;
  logic [NIBBLES-1:0][CODE_W-1:0] charNext;

  assign feedBit = strb.dataBit ^ (^(lfsr & TAP_MASK));

  for (genvar n = 0; n < NIBBLES; n++) begin : g_char
    assign charNext[n] = nibbleToCode(lfsr[n*NIB_W +: NIB_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr      <= '0;
      signature <= '0;
      chars     <= '0;
      sigValid  <= 1'b0;
    end else begin
      sigValid <= strb.closeEn;
      if (strb.closeEn) begin
        signature <= lfsr;
        chars     <= charNext;
        lfsr      <= '0;
      end else if (strb.shiftEn) begin
        lfsr <= {feedBit, lfsr[SIG_W-1:1]};
      end
    end
  end

endmodule

// File: rtl/gated_sig_analyzer.sv
module gated_sig_analyzer
  import sigan_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [15:0]      TAP_MASK    = 16'h0291
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clkEdgeSel,
  input  logic        startEdgeSel,
  input  logic        stopEdgeSel,
  input  logic        probeClk,
  input  logic        startIn,
  input  logic        stopIn,
  input  logic        dataIn,
  output logic        sigValid,
  output logic [15:0] signature,
  output logic [4:0]  char0,
  output logic [4:0]  char1,
  output logic [4:0]  char2,
  output logic [4:0]  char3
);

  logic [3:0]                     syncBus;
  sigan_strobe_t                  strb;
  logic [NIBBLES-1:0][CODE_W-1:0] chars;

  sigan_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({probeClk, startIn, stopIn, dataIn}),
    .syncOut (syncBus)
  );

  sigan_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .clkEdgeSel   (clkEdgeSel),
    .startEdgeSel (startEdgeSel),
    .stopEdgeSel  (stopEdgeSel),
    .pclkS        (syncBus[3]),
    .startS       (syncBus[2]),
    .stopS        (syncBus[1]),
    .dataS        (syncBus[0]),
    .strb         (strb)
  );

  sigan_datapath #(.TAP_MASK(TAP_MASK)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .sigValid  (sigValid),
    .signature (signature),
    .chars     (chars)
  );

  assign char0 = chars[0];
  assign char1 = chars[1];
  assign char2 = chars[2];
  assign char3 = chars[3];

endmodule

// File: rtl/sigan_chk.sv
module sigan_chk
  import sigan_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          sigValid,
  input logic [15:0]   signature,
  input logic [4:0]    char0,
  input logic [4:0]    char1,
  input logic [4:0]    char2,
  input logic [4:0]    char3,
  input sigan_strobe_t strb
);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.shiftEn, strb.closeEn}));

  // R4
  close_publish_chk: assert property (@(posedge clk) disable iff (rst)
    strb.closeEn |=> sigValid);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sigValid |=> !sigValid);

  // R8
  sig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sigValid |-> $stable(signature));

  // R9
  char_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sigValid |-> $stable({char0, char1, char2, char3}));

endmodule

bind gated_sig_analyzer sigan_chk u_sigChk (
  .clk       (clk),
  .rst       (rst),
  .sigValid  (sigValid),
  .signature (signature),
  .char0     (char0),
  .char1     (char1),
  .char2     (char2),
  .char3     (char3),
  .strb      (strb)
);

// File: tb/gated_sig_analyzer_bench.sv
`timescale 1ns/1ps
module gated_sig_analyzer_bench;

  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkEdgeSel = 1'b0, startEdgeSel = 1'b1, stopEdgeSel = 1'b1;
  logic probeClk = 1'b1, startIn = 1'b0, stopIn = 1'b0, dataIn = 1'b0;
  logic        sigValid;
  logic [15:0] signature;
  logic [4:0]  char0, char1, char2, char3;

  int total = 0, bad = 0, validCount = 0, expCount = 0;
  logic        mOpen, mPrevS, mPrevP;
  logic [15:0] mReg, expSig;

  always #2 clk = ~clk;

  gated_sig_analyzer u_gated_sig_analyzer (
    .clk(clk), .rst(rst), .clkEdgeSel(clkEdgeSel), .startEdgeSel(startEdgeSel),
    .stopEdgeSel(stopEdgeSel), .probeClk(probeClk), .startIn(startIn),
    .stopIn(stopIn), .dataIn(dataIn), .sigValid(sigValid), .signature(signature),
    .char0(char0), .char1(char1), .char2(char2), .char3(char3)
  );

  always @(posedge clk) if (!rst && sigValid) validCount++;

  function automatic logic [15:0] stepReg(input logic [15:0] r, input logic d);
    logic fb;
    fb = d ^ r[0] ^ r[4] ^ r[7] ^ r[9];
    return {fb, r[15:1]};
  endfunction

  function automatic logic [4:0] expCode(input logic [3:0] n);
    case (n)
      4'd0: return 5'd0;   4'd8: return 5'd1;   4'd4: return 5'd2;   4'd12: return 5'd3;
      4'd2: return 5'd4;   4'd10: return 5'd5;  4'd6: return 5'd6;   4'd14: return 5'd7;
      4'd1: return 5'd8;   4'd9: return 5'd9;   4'd5: return 5'd10;  4'd13: return 5'd12;
      4'd3: return 5'd15;  4'd11: return 5'd17; 4'd7: return 5'd25;  default: return 5'd30;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check(req, "valid count", validCount, expCount);
    check(req, "signature", int'(signature), int'(expSig));
    check("R9", "char0", int'(char0), int'(expCode(expSig[3:0])));
    check("R9", "char1", int'(char1), int'(expCode(expSig[7:4])));
    check("R9", "char2", int'(char2), int'(expCode(expSig[11:8])));
    check("R9", "char3", int'(char3), int'(expCode(expSig[15:12])));
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic ce, input logic se, input logic pe,
                         input logic s, input logic p);
    @(negedge clk);
    rst = 1'b1;
    clkEdgeSel = ce; startEdgeSel = se; stopEdgeSel = pe;
    probeClk = !ce; startIn = s; stopIn = p; dataIn = 1'b0;
    waitCycles(6);
    validCount = 0; expCount = 0;
    mOpen = 1'b0; mPrevS = !se; mPrevP = !pe; mReg = '0; expSig = '0;
    rst = 1'b0;
    waitCycles(2);
  endtask

  // One probe sample: set levels, make the active edge, return to idle.
  task automatic tick(input logic s, input logic p, input logic d);
    startIn = s; stopIn = p; dataIn = d;
    waitCycles(HOLD);
    probeClk = clkEdgeSel;
    if (!mOpen && s != mPrevS && s == startEdgeSel) begin
      mOpen = 1'b1; mReg = stepReg(mReg, d);
    end else if (mOpen && p != mPrevP && p == stopEdgeSel) begin
      mOpen = 1'b0; expSig = mReg; mReg = '0; expCount++;
    end else if (mOpen) begin
      mReg = stepReg(mReg, d);
    end
    mPrevS = s; mPrevP = p;
    waitCycles(HOLD);
    probeClk = !clkEdgeSel;
    waitCycles(HOLD);
  endtask

  task automatic window(input logic [31:0] bits, input int len);
    tick(startEdgeSel, !stopEdgeSel, bits[0]);
    for (int i = 1; i < len; i++) tick(startEdgeSel, !stopEdgeSel, bits[i]);
    tick(startEdgeSel, stopEdgeSel, 1'b1);
    tick(!startEdgeSel, !stopEdgeSel, 1'b0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] firstSig;
    doReset(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R10 reset state
    check("R10", "sigValid", int'(sigValid), 0);
    check("R10", "signature", int'(signature), 0);
    check("R10", "chars", int'({char0, char1, char2, char3}), 0);

    // R2 R3 R4: directed window, falling probe edge
    window(32'hA5C3_1E97, 24);
    checkState("R2");
    firstSig = expSig;
    // R4 register cleared: same data gives same signature
    window(32'hA5C3_1E97, 24);
    checkState("R4");
    check("R4", "repeat signature", int'(signature), int'(firstSig));

    // R5: STOP edge while closed is ignored
    tick(1'b0, 1'b1, 1'b1);
    tick(1'b0, 1'b0, 1'b1);
    checkState("R5");
    // R5: START and STOP rise together while closed: opening wins
    tick(1'b1, 1'b1, 1'b1);
    tick(1'b0, 1'b1, 1'b0);  // START fall while open ignored
    tick(1'b1, 1'b1, 1'b1);  // START rise while open ignored
    tick(1'b1, 1'b0, 1'b0);
    checkState("R5");
    tick(1'b1, 1'b1, 1'b0);
    checkState("R5");

    // R6: START pulse between probe samples is not seen
    tick(1'b0, 1'b0, 1'b0);
    startIn = 1'b1; waitCycles(6); startIn = 1'b0; waitCycles(6);
    tick(1'b0, 1'b0, 1'b1);
    tick(1'b0, 1'b1, 1'b1);
    check("R6", "no window from glitch", validCount, expCount);
    checkState("R6");

    // R1: rising probe edge mode
    doReset(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    window(32'h0000_9B3D, 16);
    checkState("R1");

    // R7: START already active at reset counts as an edge (falling select)
    doReset(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b1);
    tick(1'b0, 1'b0, 1'b1);
    tick(1'b0, 1'b1, 1'b0);
    check("R7", "window opened on first sample", expCount, 1);
    checkState("R7");

    // R8 R9: random stimulus under random selects
    begin
      int seed;
      seed = $urandom(32'h5A17);
      for (int seg = 0; seg < 24; seg++) begin
        logic s, p;
        s = 1'($urandom);
        p = 1'($urandom);
        doReset(1'($urandom), 1'($urandom), 1'($urandom), s, p);
        for (int k = 0; k < 50; k++) begin
          if ($urandom_range(3) == 0) s = !s;
          if ($urandom_range(5) == 0) p = !p;
          tick(s, p, 1'($urandom));
          checkState("R8");
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule